// File: doc/BRIEF.md
# Ramped Stepper Pulse Generator

This block drives the step and direction inputs of a small stepper motor driver. The step rate comes from an 8-bit phase accumulator. Each clock it adds a rate increment. A ninth sum bit catches every rollover and becomes a one-cycle step pulse. That pulse is a clock enable for downstream step logic, not a derived clock. An increment of `k` gives `k/256` pulses per clock.

The increment does not jump. A ramp counter moves it one unit every `RAMP_DIV` clocks. While exactly one of the two direction buttons is held, it moves toward a supplied top rate. Otherwise it moves back toward a supplied bottom rate. Choose `RAMP_DIV` so that a full sweep takes about one second.

Direction reverses only after the motor has slowed to the bottom rate. Pressing the opposite button while running therefore decelerates, flips direction, and accelerates again. When the rate has fallen back to the bottom and no button is held, stepping stops, unless the idle-stepping parameter is set.

Top module: `step_ramp_gen`

## Requirements
- R1: The step output is high for exactly the cycles in which the 8-bit phase sum, extended by a ninth bit, rolls past 255. With a constant increment `k`, a window of `N` cycles holds `N*k/256` pulses, within one.
- R2: An increment of 128 gives a pulse every 2 cycles. An increment of 1 gives a pulse every 256 cycles.
- R3: While one direction button is held and direction already matches it, the increment rises by exactly 1 once every `RAMP_DIV` cycles. It starts from `rate_lo`.
- R4: When no single button is held, the increment falls by 1 once every `RAMP_DIV` cycles until it equals `rate_lo`.
- R5: The increment saturates at `rate_hi` when ramping up and at `rate_lo` when ramping down. It never wraps, so with `rate_hi` = 255 the rate stays at 255 while held.
- R6: `dir` is 1 for the up button and 0 for the down button. It changes only in a cycle where the increment equals `rate_lo`. Pressing the opposite button while running first ramps down, then flips `dir`.
- R7: Both buttons held together act as no button held.
- R8: With `IDLE_STEP` = 0, no step pulse appears once the increment is at `rate_lo` and no single button is held.
- R9: Synchronous active-low reset clears `step` and `dir` to 0, loads the increment with `rate_lo`, and clears the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_up | input | 1 | Up button (already debounced), active high |
| btn_dn | input | 1 | Down button (already debounced), active high |
| rate_lo | input | ACC_W | Bottom increment, 1 to rate_hi |
| rate_hi | input | ACC_W | Top increment, rate_lo to 255 |
| step | output | 1 | One-cycle step pulse (clock enable) |
| dir | output | 1 | Direction: 1 up, 0 down |

## Verification
The hardest state to reach is a reversal at speed. The motor must first be at its top rate in one direction, then the opposite button is pressed. The bench holds up long enough to saturate, then switches to down. It checks that `dir` still reads 1 a few cycles later, that it reads 0 once the ramp down is complete, and that the rate has climbed back to the top afterwards. Mid-ramp rate is checked by counting pulses over a window and comparing against the sum of a cycle-by-cycle model of the ramp.

// File: rtl/srg_pkg.sv
// Package: shared widths and types for the ramped step generator.
// Assumes: accumulator width of 8 (rate 1..255).
package srg_pkg;
    localparam int ACC_W = 8;
    typedef logic [ACC_W-1:0] rate_t;
    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_UP   = 2'd1,
        REQ_DN   = 2'd2
    } btn_req_e;
endpackage

// File: rtl/srg_dir_ctl.sv
// Module: srg_dir_ctl
// Decodes the two buttons into a single request and holds the direction.
// Direction may only change while the rate sits at its bottom value.
// Assumes: buttons are debounced and synchronous to clk.
module srg_dir_ctl
    import srg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic btn_up,
    input  logic btn_dn,
    input  logic at_lo,
    output logic held,
    output logic going,
    output logic dir
);
    btn_req_e req;
    logic     want_up;

    // Map the button pair to a request; both pressed counts as none.
    always_comb begin
        unique case ({btn_up, btn_dn})
            2'b10:   req = REQ_UP;
            2'b01:   req = REQ_DN;
            default: req = REQ_NONE;
        endcase
    end

    assign held    = (req != REQ_NONE);
    assign want_up = (req == REQ_UP);

    // Latch the requested direction only at the bottom rate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir <= 1'b0;
        end else if (held && at_lo) begin
            dir <= want_up;
        end
    end

    // Accelerate only when a request exists and direction agrees with it.
    assign going = held && (dir == want_up);
endmodule

// File: rtl/srg_ramp.sv
// Module: srg_ramp
// Moves the rate increment one unit toward its target every RAMP_DIV
// clocks. Target is rate_hi while accelerating, else rate_lo.
// Assumes: 1 <= rate_lo <= rate_hi; limits change only during reset.
module srg_ramp
    import srg_pkg::*;
#(
    parameter int RAMP_DIV = 196850
)(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  going,
    input  rate_t rate_lo,
    input  rate_t rate_hi,
    output rate_t rate,
    output logic  at_lo
);
    localparam int DIV_W = (RAMP_DIV > 1) ? $clog2(RAMP_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(RAMP_DIV - 1);

    logic [DIV_W-1:0] div_cnt;
    logic             tick;
    rate_t            target;

    // Free-running divider producing one ramp tick per RAMP_DIV clocks.
    always_ff @(posedge clk) begin
        if (!rst_n || tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    assign tick   = (div_cnt == DIV_LAST);
    assign target = going ? rate_hi : rate_lo;

    // Step the rate one unit toward the target, saturating on arrival.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate <= rate_lo;
        end else if (tick) begin
            if (rate < target) begin
                rate <= rate + 1'b1;
            end else if (rate > target) begin
                rate <= rate - 1'b1;
            end
        end
    end

    assign at_lo = (rate == rate_lo);
endmodule

// File: rtl/srg_phase_acc.sv
// Module: srg_phase_acc
// Phase accumulator; the extra top bit of the sum is the rollover pulse.
// When not running the phase is cleared so the next start is clean.
// Assumes: rate is stable or changes by one unit per ramp tick.
module srg_phase_acc
    import srg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  rate_t rate,
    output logic  pulse
);
    logic [ACC_W:0] phase;

    // Add the increment to the low bits; bit ACC_W flags a rollover.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase <= '0;
        end else begin
            phase <= {1'b0, phase[ACC_W-1:0]} + {1'b0, rate};
        end
    end

    assign pulse = phase[ACC_W];
endmodule

// File: rtl/step_ramp_gen.sv
// Module: step_ramp_gen (top)
// Ramped step/direction generator for a stepper driver. Ties together the
// button/direction control, the rate ramp and the phase accumulator.
// Assumes: debounced synchronous buttons; 1 <= rate_lo <= rate_hi.
module step_ramp_gen
    import srg_pkg::*;
#(
    parameter int RAMP_DIV  = 196850,
    parameter bit IDLE_STEP = 1'b0
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             btn_up,
    input  logic             btn_dn,
    input  logic [ACC_W-1:0] rate_lo,
    input  logic [ACC_W-1:0] rate_hi,
    output logic             step,
    output logic             dir
);
    logic  btn_held;
    logic  going;
    logic  at_lo;
    logic  run;
    rate_t rate_cur;

    srg_dir_ctl u_dir (
        .clk    (clk),
        .rst_n  (rst_n),
        .btn_up (btn_up),
        .btn_dn (btn_dn),
        .at_lo  (at_lo),
        .held   (btn_held),
        .going  (going),
        .dir    (dir)
    );

    srg_ramp #(.RAMP_DIV(RAMP_DIV)) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .going   (going),
        .rate_lo (rate_lo),
        .rate_hi (rate_hi),
        .rate    (rate_cur),
        .at_lo   (at_lo)
    );

    // Step while accelerating, while still slowing down, or if idling is allowed.
    assign run = going || !at_lo || IDLE_STEP;

    srg_phase_acc u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .rate  (rate_cur),
        .pulse (step)
    );
endmodule

// File: rtl/srg_checker.sv
// Module: srg_checker
// Temporal checks on the ramped step generator, bound into the top.
module srg_checker
    import srg_pkg::*;
#(
    parameter bit IDLE_STEP = 1'b0
)(
    input logic  clk,
    input logic  rst_n,
    input logic  btn_up,
    input logic  btn_dn,
    input rate_t rate_lo,
    input rate_t rate_hi,
    input logic  step,
    input logic  dir,
    input rate_t rate_cur,
    input logic  btn_held
);
    // R3/R4: the rate only ever moves by a single unit
    p_unit_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(rate_cur)) |->
            (rate_cur == $past(rate_cur) + 8'd1 || rate_cur == $past(rate_cur) - 8'd1));

    // R5: no wrap from the top code to zero
    p_no_wrap_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rate_cur) == 8'hFF) |-> rate_cur != 8'h00);

    // R5: no wrap from zero to the top code
    p_no_wrap_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rate_cur) == 8'h00) |-> rate_cur != 8'hFF);

    // R6: direction changes only at the bottom rate
    p_dir_at_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(dir)) |-> $past(rate_cur) == $past(rate_lo));

    // R7: both buttons never raise the rate
    p_both_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (btn_up && btn_dn && rate_cur >= rate_lo) |=> rate_cur <= $past(rate_cur));

    // R8: quiet when idle at the bottom rate
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!IDLE_STEP && !btn_held && rate_cur == rate_lo) |=> !step);
endmodule

bind step_ramp_gen srg_checker #(.IDLE_STEP(IDLE_STEP)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .btn_up   (btn_up),
    .btn_dn   (btn_dn),
    .rate_lo  (rate_lo),
    .rate_hi  (rate_hi),
    .step     (step),
    .dir      (dir),
    .rate_cur (rate_cur),
    .btn_held (btn_held)
);

// File: tb/sim_step_ramp_gen.sv
`timescale 1ns/1ps
// Bench for step_ramp_gen: vector table of constant-rate cases, then
// directed ramp, reversal, saturation and reset checks.
module sim_step_ramp_gen;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       btn_up = 1'b0;
    logic       btn_dn = 1'b0;
    logic [7:0] rate_lo = 8'd1;
    logic [7:0] rate_hi = 8'd1;
    logic       step;
    logic       dir;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    step_ramp_gen #(.RAMP_DIV(DIV), .IDLE_STEP(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .btn_up(btn_up), .btn_dn(btn_dn),
        .rate_lo(rate_lo), .rate_hi(rate_hi), .step(step), .dir(dir)
    );

    typedef struct packed {
        logic       up;
        logic       dn;
        logic [7:0] rate;
        int         cyc;
        int         exp_p;
        logic       exp_dir;
    } vec_t;

    // rate_lo == rate_hi, so the rate is constant during each row
    localparam vec_t VECS [7] = '{
        '{1'b1, 1'b0, 8'd128, 256, 128, 1'b1},  // R2 half rate
        '{1'b0, 1'b1, 8'd1,   768, 3,   1'b0},  // R2 slowest
        '{1'b1, 1'b0, 8'd64,  256, 64,  1'b1},  // R1
        '{1'b0, 1'b1, 8'd200, 256, 200, 1'b0},  // R1
        '{1'b1, 1'b0, 8'd255, 256, 255, 1'b1},  // R1 top code
        '{1'b1, 1'b1, 8'd50,  256, 0,   1'b0},  // R7 both = none
        '{1'b0, 1'b0, 8'd30,  256, 0,   1'b0}   // R8 idle
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [7:0] lo, input logic [7:0] hi);
        btn_up = 1'b0;
        btn_dn = 1'b0;
        rst_n = 1'b0;
        rate_lo = lo;
        rate_hi = hi;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic count_pulses(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (step) c++;
        end
    endtask

    task automatic near(input int act, input int exp, input int tol, input string req);
        check((act >= exp - tol) && (act <= exp + tol), req, act, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int c;
        int sum;
        int r;

        // R9: reset state
        rate_lo = 8'd40;
        rate_hi = 8'd40;
        repeat (3) @(negedge clk);
        check(step == 1'b0, "R9 step in reset", int'(step), 0);
        check(dir == 1'b0, "R9 dir in reset", int'(dir), 0);
        rst_n = 1'b1;
        count_pulses(300, c);
        check(c == 0, "R9 quiet after reset", c, 0);

        // Vector table walk
        foreach (VECS[i]) begin
            do_reset(VECS[i].rate, VECS[i].rate);
            btn_up = VECS[i].up;
            btn_dn = VECS[i].dn;
            repeat (4) @(negedge clk);
            count_pulses(VECS[i].cyc, c);
            near(c, VECS[i].exp_p, 1, $sformatf("R1 R2 row %0d pulses", i));
            check(dir == VECS[i].exp_dir, $sformatf("R6 row %0d dir", i), int'(dir), int'(VECS[i].exp_dir));
        end

        // R2: exact every-other-cycle spacing at rate 128
        do_reset(8'd128, 8'd128);
        btn_up = 1'b1;
        repeat (6) @(negedge clk);
        c = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (step) c++;
            if (i > 0) check(step != r[0], "R2 alternation", int'(step), int'(!r[0]));
            r = int'(step);
        end

        // R3: mid-ramp rate follows one unit per DIV cycles
        do_reset(8'd10, 8'd200);
        btn_up = 1'b1;
        repeat (100) @(negedge clk);
        sum = 0;
        for (int k = 100; k < 356; k++) begin
            r = 10 + k / DIV;
            if (r > 200) r = 200;
            sum += r;
        end
        count_pulses(256, c);
        near(c, sum / 256, 3, "R3 mid-ramp rate");

        // R5: saturates at the top rate
        repeat (1000) @(negedge clk);
        count_pulses(256, c);
        near(c, 200, 1, "R5 top saturation");

        // R6: reversal waits for the bottom rate
        btn_up = 1'b0;
        btn_dn = 1'b1;
        repeat (8) @(negedge clk);
        check(dir == 1'b1, "R6 dir held while fast", int'(dir), 1);
        repeat (1000) @(negedge clk);
        check(dir == 1'b0, "R6 dir flipped at bottom", int'(dir), 0);
        repeat (1000) @(negedge clk);
        count_pulses(256, c);
        near(c, 200, 1, "R6 re-accelerated");

        // R4/R8: release ramps down and then stops
        btn_dn = 1'b0;
        repeat (1200) @(negedge clk);
        count_pulses(300, c);
        check(c == 0, "R4 R8 stopped after release", c, 0);

        // R7: both pressed while running decelerates to a stop
        do_reset(8'd10, 8'd100);
        btn_up = 1'b1;
        repeat (600) @(negedge clk);
        btn_dn = 1'b1;
        repeat (600) @(negedge clk);
        count_pulses(300, c);
        check(c == 0, "R7 both pressed stops", c, 0);
        check(dir == 1'b1, "R7 dir kept", int'(dir), 1);

        // R5: no wrap at code 255
        do_reset(8'd250, 8'd255);
        btn_up = 1'b1;
        repeat (200) @(negedge clk);
        count_pulses(256, c);
        near(c, 255, 1, "R5 no wrap at 255");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule